// File: doc/BRIEF.md
# Batch-Drain Byte Buffer with Serial Output

This block lets a fast byte producer feed a slow asynchronous serial transmitter without losing data. The producer writes bytes into an internal buffer at full speed. Nothing goes out on the serial line while the buffer is filling. Once the buffer reports full, the block raises a pause request to the producer and empties the buffer one byte at a time through an 8N1 transmitter. It keeps draining until the buffer reports empty, and then drops the pause so the producer can refill.

The producer marks its final byte with a "last" qualifier. After that write, the block drains whatever is buffered even if the buffer never filled. It then parks in a terminal stopped state and discards any further writes. Only a reset leaves this state.

The buffer shows its occupancy through three active-low flags: full, empty and exactly-one-byte. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `fifo_uart_bridge`

## Requirements
- R1: After reset, pause is 0, full_n is 1, empty_n is 0, first_n is 1, stopped is 0 and txd idles at 1.
- R2: Each byte goes out as an 8N1 frame on txd. The frame is one start bit at 0, then eight data bits with the least significant bit first, then one stop bit at 1. Every bit lasts CLK_HZ/BAUD clock cycles, and txd is 1 whenever no frame is being sent.
- R3: A write presented while the buffer holds DEPTH bytes is discarded. Occupancy never exceeds DEPTH, and the stored bytes are left untouched.
- R4: full_n is 0 exactly when DEPTH bytes are held. empty_n is 0 exactly when no byte is held. first_n is 0 exactly when one byte is held.
- R5: Before the buffer first becomes full, and with no last marker seen, no byte is read and txd stays at 1.
- R6: pause is 1 from the cycle full_n goes to 0 until the cycle in which empty_n is 0, and returns to 0 on the following cycle.
- R7: The buffer is read only when the transmitter is idle, with exactly one read per transmitted frame. Bytes leave in the order they were written, each exactly once.
- R8: A write with wr_last at 1 starts a drain even if the buffer is not full. When the buffer empties, stopped rises to 1 and pause stays at 1.
- R9: Once stopped is 1 it stays 1. Writes are then discarded, so empty_n stays 0 and no further frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 8 | Producer byte |
| wr_last | input | 1 | Marks the current write as the final byte |
| pause | output | 1 | Producer must stop writing while this is 1 |
| full_n | output | 1 | Active-low buffer full flag |
| empty_n | output | 1 | Active-low buffer empty flag |
| first_n | output | 1 | Active-low flag: exactly one byte buffered |
| txd | output | 1 | Serial output, idles high |
| stopped | output | 1 | Terminal state reached after the final drain |

## Verification
The properties checked on every cycle are the following:
- the occupancy bound;
- that a write against a full buffer leaves the occupancy unchanged;
- that every read lands while the transmitter is idle and starts a frame;
- that no read happens outside a pause window;
- that pause only falls after an empty flag;
- that the stopped state is sticky and frozen.

Three things need the bench scenarios: the serial frame contents and their order, the absence of traffic before the buffer first fills, and the exact timing of the pause release relative to the empty flag. The bench shows the release while the last frame of a batch is still on the line and a refill is already running. The scenarios also show that discarded writes never appear on the line, both against a full buffer and after the stop.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_STOP  = 2'd2
  } drain_state_e;

  localparam int FRAME_BITS = 10;
endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full_n,
  output logic          empty_n,
  output logic          first_n,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic [LW-1:0] level_nx;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_en && (level != LW'(DEPTH));
  assign rd_ok = rd_en && (level != '0);

  always_comb begin
    wptr_nx  = wptr;
    rptr_nx  = rptr;
    level_nx = level;
    if (wr_ok) wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    if (rd_ok) rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    if (wr_ok && !rd_ok) level_nx = level + 1'b1;
    else if (rd_ok && !wr_ok) level_nx = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr_nx;
      rptr  <= rptr_nx;
      level <= level_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rptr];
  assign full_n  = (level != LW'(DEPTH));
  assign empty_n = (level != '0);
  assign first_n = (level != LW'(1));
endmodule

// File: rtl/uart_tx8n1.sv
module uart_tx8n1 #(
  parameter int CPB = 1302,
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       txd
);
  import bridge_pkg::*;

  logic [FRAME_BITS-1:0] sh, sh_nx;
  logic [CW-1:0]         baud, baud_nx;
  logic [3:0]            bitn, bitn_nx;
  logic                  busy_nx;
  logic                  tick;

  assign tick = (baud == CW'(CPB - 1));

  always_comb begin
    sh_nx   = sh;
    baud_nx = baud;
    bitn_nx = bitn;
    busy_nx = busy;
    if (!busy) begin
      if (start) begin
        sh_nx   = {1'b1, data, 1'b0};
        baud_nx = '0;
        bitn_nx = '0;
        busy_nx = 1'b1;
      end
    end else if (tick) begin
      baud_nx = '0;
      if (bitn == 4'(FRAME_BITS - 1)) begin
        busy_nx = 1'b0;
      end else begin
        bitn_nx = bitn + 1'b1;
        sh_nx   = {1'b1, sh[FRAME_BITS-1:1]};
      end
    end else begin
      baud_nx = baud + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      baud <= '0;
      bitn <= '0;
      busy <= 1'b0;
    end else begin
      sh   <= sh_nx;
      baud <= baud_nx;
      bitn <= bitn_nx;
      busy <= busy_nx;
    end
  end

  assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full_n,
  input  logic empty_n,
  input  logic last_acc,
  input  logic tx_busy,
  output logic rd_en,
  output logic pause,
  output logic stopped
);
  import bridge_pkg::*;

  drain_state_e state, state_nx;
  logic         last_seen, last_seen_nx;

  always_comb begin
    state_nx     = state;
    last_seen_nx = last_seen | last_acc;
    case (state)
      ST_FILL: begin
        if (!full_n || (last_seen && empty_n)) state_nx = ST_DRAIN;
        else if (last_seen)                    state_nx = ST_STOP;
      end
      ST_DRAIN: begin
        if (!empty_n) state_nx = last_seen ? ST_STOP : ST_FILL;
      end
      default: state_nx = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      last_seen <= 1'b0;
    end else begin
      state     <= state_nx;
      last_seen <= last_seen_nx;
    end
  end

  assign rd_en   = (state == ST_DRAIN) && empty_n && !tx_busy;
  assign pause   = (state != ST_FILL) || !full_n || last_seen;
  assign stopped = (state == ST_STOP);
endmodule

// File: rtl/fifo_uart_bridge.sv
module fifo_uart_bridge #(
  parameter int DEPTH  = 512,
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 38_400,
  localparam int CPB   = CLK_HZ / BAUD,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  output logic       pause,
  output logic       full_n,
  output logic       empty_n,
  output logic       first_n,
  output logic       txd,
  output logic       stopped
);
  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          wr_acc, last_acc, fifo_rd, tx_busy;
  logic [7:0]    head;
  logic [LW-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign wr_acc   = wr_en && !stopped;
  assign last_acc = wr_acc && wr_last && full_n;

  bridge_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_acc), .wr_data(wr_data),
    .rd_en(fifo_rd), .rd_data(head), .full_n(full_n), .empty_n(empty_n),
    .first_n(first_n), .level(level)
  );

  drain_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .full_n(full_n), .empty_n(empty_n),
    .last_acc(last_acc), .tx_busy(tx_busy), .rd_en(fifo_rd),
    .pause(pause), .stopped(stopped)
  );

  uart_tx8n1 #(.CPB(CPB)) u_tx (
    .clk(clk), .rst_n(rst_s), .start(fifo_rd), .data(head),
    .busy(tx_busy), .txd(txd)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int DEPTH = 512,
  parameter int LW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pause,
  input logic          full_n,
  input logic          empty_n,
  input logic          stopped,
  input logic          txd,
  input logic          wr_acc,
  input logic          fifo_rd,
  input logic          tx_busy,
  input logic [LW-1:0] level
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !full_n && !fifo_rd) |=> $stable(level));
  a_r7_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !tx_busy);
  a_r7_read_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> tx_busy);
  a_r5_read_only_paused: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> pause);
  a_r6_full_holds_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> pause);
  a_r6_release_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause) |-> $past(!empty_n));
  a_r2_line_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r9_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (stopped && $stable(level)));
endmodule

bind fifo_uart_bridge bridge_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause(pause), .full_n(full_n),
  .empty_n(empty_n), .stopped(stopped), .txd(txd), .wr_acc(wr_acc),
  .fifo_rd(fifo_rd), .tx_busy(tx_busy), .level(level)
);

// File: tb/fifo_uart_bridge_bench.sv
`timescale 1ns/1ps
module fifo_uart_bridge_bench;
  localparam int DEPTH  = 8;
  localparam int CLK_HZ = 400_000;
  localparam int BAUD   = 100_000;
  localparam int CPB    = CLK_HZ / BAUD;

  logic clk, rst_n, wr_en, wr_last;
  logic [7:0] wr_data;
  logic pause, full_n, empty_n, first_n, txd, stopped;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] sb_q[$];

  fifo_uart_bridge #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_fifo_uart_bridge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_last(wr_last), .pause(pause), .full_n(full_n), .empty_n(empty_n),
    .first_n(first_n), .txd(txd), .stopped(stopped)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic put(input logic [7:0] d, input bit last, input bit keep);
    wr_en = 1'b1; wr_data = d; wr_last = last;
    if (keep) sb_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  // monitor: decodes 8N1 frames and compares with the scoreboard
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (CPB/2) @(negedge clk);
        check(txd === 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        check(txd === 1'b1, "R2 stop bit", txd, 1);
        if (sb_q.size() == 0) check(1'b0, "R7/R9 unexpected frame", got, 0);
        else begin
          logic [7:0] exp;
          exp = sb_q.pop_front();
          check(got === exp, "R7 byte order", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic saw_tx;
    wr_en = 0; wr_last = 0; wr_data = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pause === 1'b0,   "R1 pause",   pause,   0);
    check(full_n === 1'b1,  "R1 full_n",  full_n,  1);
    check(empty_n === 1'b0, "R1 empty_n", empty_n, 0);
    check(first_n === 1'b1, "R1 first_n", first_n, 1);
    check(stopped === 1'b0, "R1 stopped", stopped, 0);
    check(txd === 1'b1,     "R1 txd",     txd,     1);

    // batch 1: partial fill, R4 flags and R5 no drain
    put(8'h3C, 0, 1);
    check(first_n === 1'b0 && empty_n === 1'b1, "R4 one byte", {first_n, empty_n}, 2'b01);
    put(8'h81, 0, 1);
    check(first_n === 1'b1, "R4 two bytes", first_n, 1);
    for (int i = 2; i < DEPTH - 1; i++) put(8'(8'h10 + i), 0, 1);
    saw_tx = 0;
    repeat (40) begin @(negedge clk); if (txd !== 1'b1) saw_tx = 1; end
    check(!saw_tx, "R5 no traffic while filling", saw_tx, 0);
    check(pause === 1'b0 && full_n === 1'b1, "R5 not paused below full", {pause, full_n}, 2'b01);
    put(8'hC7, 0, 1);
    check(full_n === 1'b0, "R4 full flag", full_n, 0);
    check(pause === 1'b1, "R6 pause on full", pause, 1);
    put(8'hEE, 0, 0);  // producer violation: discarded
    check(full_n === 1'b0, "R3 write while full dropped", full_n, 0);

    // wait for empty, R6 release timing
    while (empty_n !== 1'b0) @(negedge clk);
    check(pause === 1'b1, "R6 pause held in empty cycle", pause, 1);
    @(negedge clk);
    check(pause === 1'b0, "R6 pause released", pause, 0);

    // batch 2 while last frame still on the line
    put(8'h00, 0, 1); put(8'hFF, 0, 1); put(8'h55, 0, 1); put(8'hAA, 0, 1);
    put(8'hA5, 0, 1); put(8'h5A, 0, 1); put(8'h01, 0, 1); put(8'h80, 0, 1);
    check(pause === 1'b1, "R6 pause on second full", pause, 1);
    while (pause !== 1'b0) @(negedge clk);

    // final batch with last marker
    put(8'h12, 0, 1); put(8'h34, 0, 1); put(8'h9B, 1, 1);
    check(pause === 1'b1, "R8 pause after last", pause, 1);
    check(stopped === 1'b0, "R8 not yet stopped", stopped, 0);
    while (stopped !== 1'b1) @(negedge clk);
    check(empty_n === 1'b0 && pause === 1'b1, "R8 stopped empty paused", {empty_n, pause}, 2'b01);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4 * CPB) @(negedge clk);

    // R9 writes after stop discarded
    put(8'h77, 0, 0);
    repeat (60) @(negedge clk);
    check(empty_n === 1'b0, "R9 write after stop dropped", empty_n, 0);
    check(stopped === 1'b1 && txd === 1'b1, "R9 stop sticky line idle", {stopped, txd}, 2'b11);
    finish_run();
  end
endmodule